// File: doc/BRIEF.md
# Two-Channel DMA Sequencer with Burst Hint

This block sequences memory transfers for two DMA channels over a simple bus-master handshake. Each channel moves data either as single 32-bit accesses or as 16-byte units made of four 32-bit beats at consecutive word addresses. While a 16-byte unit is in progress, the block raises a burst-hint output on every beat that another beat in the same aligned 16-byte block will follow. External bridge logic can therefore keep a burst open without comparing the present and next addresses itself.

Each channel has its own address and transfer count, loaded through a register-style port. It also has a request source: free-running auto request, a latched rising edge on an external pin, the level of that pin, or a request from an on-chip module. The hint is suppressed for single transfers, for channels marked as addressing SDRAM/DRAM, and for the level and on-chip request sources. A global enable gates all activity. When it is cleared, the bus cycle in flight always finishes before both channels stop. Address and count keep the values reached, so re-enabling resumes the transfer.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, bus_req, bus_hint and both te_flag bits are 0.
- R2: With cfg_mode16 set for the channel, one unit is four beats with bus_burst=1 at the loaded 16-byte-aligned address plus 0, 4, 8 and 12. The next unit continues at plus 16. With cfg_mode16 clear, a unit is one beat with bus_burst=0, and successive units step the address by 4.
- R3: In 16-byte mode the hint is 1 on the first three beats of a unit (address bits [3:2] = 0, 1, 2) and 0 on the fourth (bits [3:2] = 3). The hint is never 1 while bus_req is 0.
- R4: bus_hint stays 0 for every beat of a channel whose cfg_mode16 bit is 0 or whose cfg_memdram bit is 1.
- R5: The request mode is the channel's 2-bit field of cfg_reqmode: 0 auto, 1 external edge, 2 external level, 3 on-chip module. The hint may be 1 only in modes 0 and 1.
- R6: The channel count decrements by one per completed unit. When it reaches zero, the channel's te_flag is set and the channel requests no further units.
- R7: When both channels have a pending request at the start of a unit, channel 0 is served first.
- R8: In edge mode, one rising edge of ext_req is latched and produces exactly one unit. The latch is cleared when that unit starts.
- R9: te_flag stays set until the matching te_clear bit is pulsed. While the flag is set, the channel starts no unit, even with a nonzero count and a request.
- R10: When cfg_enable falls during a beat, bus_req and bus_addr are held until bus_done. Both channels then go idle, with address advanced past the completed beats and count unchanged. No unit starts while cfg_enable is 0, and re-enabling resumes from the held address.
- R11: If the beat interrupted by clearing cfg_enable is the last beat of the last unit, te_flag is set as on a normal finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global enable; clearing it aborts at the next bus_done |
| cfg_chan_en | input | 2 | Per-channel enable |
| cfg_mode16 | input | 2 | Per-channel 16-byte unit mode |
| cfg_memdram | input | 2 | Per-channel flag: target is SDRAM/DRAM |
| cfg_reqmode | input | 4 | Per-channel request mode, 2 bits each (channel i at [2i+1:2i]) |
| ld_valid | input | 1 | Load address and count for ld_chan |
| ld_chan | input | 1 | Channel selected for a load |
| ld_addr | input | 32 | Start address (low two bits ignored) |
| ld_count | input | 16 | Number of units |
| te_clear | input | 2 | Per-channel pulse clearing te_flag |
| ext_req | input | 2 | External request pins |
| mod_req | input | 2 | On-chip module requests |
| bus_req | output | 1 | Bus access request, held until bus_done |
| bus_addr | output | 32 | Beat address |
| bus_burst | output | 1 | Beat belongs to a 16-byte unit |
| bus_hint | output | 1 | Next beat continues the current burst |
| bus_done | input | 1 | Current bus cycle completes this clock |
| te_flag | output | 2 | Per-channel transfer-end flags |

## Verification
The bench drops the enable while a beat is stalled. A design that cut the cycle short would drop bus_req early. One that rewound or realigned the address on resume would repeat beats 0x3000 and 0x3004 instead of continuing at 0x3008. One that decremented the count on an aborted partial unit would finish one unit early. It also aborts on the sole beat of a final unit, where a design that treated abort as a plain stop would never raise te_flag. A single edge pulse must give exactly four beats, which catches a latch that is not cleared at unit start. Reloading a count while the flag is still set catches a channel that restarts before software acknowledges the end.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        RQ_AUTO   = 2'd0,
        RQ_EDGE   = 2'd1,
        RQ_LEVEL  = 2'd2,
        RQ_MODULE = 2'd3
    } rq_mode_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_XFER = 1'b1
    } sq_state_e;

    // Burst continuation is only signalled for request sources that give
    // whole-unit service.
    function automatic logic hint_allowed(rq_mode_e m);
        return (m == RQ_AUTO) || (m == RQ_EDGE);
    endfunction

endpackage

// File: rtl/dma_req_front.sv
module dma_req_front
    import dma_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rq_mode_e mode,
    input  logic     ext_req,
    input  logic     mod_req,
    input  logic     blocked,
    input  logic     take,
    output logic     pend
);

    typedef struct packed {
        logic prev;
        logic latched;
    } front_t;

    front_t front_d, front_q;

    always_comb begin
        front_d.prev    = ext_req;
        front_d.latched = front_q.latched & ~take;
        if (mode == RQ_EDGE && ext_req && !front_q.prev && !blocked)
            front_d.latched = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    always_comb begin
        case (mode)
            RQ_AUTO:  pend = 1'b1;
            RQ_EDGE:  pend = front_q.latched;
            RQ_LEVEL: pend = ext_req;
            default:  pend = mod_req;
        endcase
    end

endmodule

// File: rtl/dma_hint_gate.sv
module dma_hint_gate
    import dma_seq_pkg::*;
(
    input  logic     active,
    input  logic     mode16,
    input  logic     memdram,
    input  rq_mode_e mode,
    input  logic     last_beat,
    output logic     hint
);

    assign hint = active && mode16 && !memdram && hint_allowed(mode) && !last_beat;

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int BEATS = 4,
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [NCH-1:0]     cfg_chan_en,
    input  logic [NCH-1:0]     cfg_mode16,
    input  logic [NCH-1:0]     cfg_memdram,
    input  logic [2*NCH-1:0]   cfg_reqmode,
    input  logic               ld_valid,
    input  logic [$clog2(NCH)-1:0] ld_chan,
    input  logic [AW-1:0]      ld_addr,
    input  logic [CW-1:0]      ld_count,
    input  logic [NCH-1:0]     te_clear,
    input  logic [NCH-1:0]     ext_req,
    input  logic [NCH-1:0]     mod_req,
    output logic               bus_req,
    output logic [AW-1:0]      bus_addr,
    output logic               bus_burst,
    output logic               bus_hint,
    input  logic               bus_done,
    output logic [NCH-1:0]     te_flag
);

    localparam int CHW = $clog2(NCH);
    localparam int LSB = $clog2(BYTES);
    localparam int BB  = $clog2(BEATS);
    localparam logic [AW-1:0] STEP     = AW'(BYTES);
    localparam logic [AW-1:0] LOW_MASK = AW'(BYTES - 1);
    localparam logic [BB-1:0] LAST_IDX = BB'(BEATS - 1);

    typedef struct packed {
        sq_state_e                st;
        logic [CHW-1:0]           ch;
        logic [NCH-1:0][AW-1:0]   addr;
        logic [NCH-1:0][CW-1:0]   cnt;
        logic [NCH-1:0]           te;
    } seq_t;

    seq_t state_d, state_q;

    logic [NCH-1:0] pend, elig, take, te_set;
    logic [CHW-1:0] pick;
    logic [AW-1:0]  cur_addr;
    logic           beat_last, unit_last;
    logic [CHW-1:0] act_ch;

    // Request front end, one per channel
    for (genvar i = 0; i < NCH; i++) begin : g_front
        dma_req_front u_front (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (rq_mode_e'(cfg_reqmode[2*i +: 2])),
            .ext_req (ext_req[i]),
            .mod_req (mod_req[i]),
            .blocked (state_q.te[i]),
            .take    (take[i]),
            .pend    (pend[i])
        );
        assign elig[i] = cfg_chan_en[i] && pend[i] && !state_q.te[i]
                         && (state_q.cnt[i] != '0);
    end

    // Fixed priority: the lowest channel index wins
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (elig[i]) pick = CHW'(i);
    end

    assign act_ch    = state_q.ch;
    assign cur_addr  = state_q.addr[state_q.ch];
    assign beat_last = (cur_addr[LSB +: BB] == LAST_IDX);
    assign unit_last = !cfg_mode16[state_q.ch] || beat_last;

    always_comb begin
        state_d = state_q;
        take    = '0;
        te_set  = '0;
        case (state_q.st)
            SQ_IDLE: begin
                if (cfg_enable && (|elig)) begin
                    state_d.st = SQ_XFER;
                    state_d.ch = pick;
                    take[pick] = 1'b1;
                end
            end
            SQ_XFER: begin
                if (bus_done) begin
                    state_d.addr[state_q.ch] = cur_addr + STEP;
                    if (unit_last) begin
                        state_d.cnt[state_q.ch] = state_q.cnt[state_q.ch] - CW'(1);
                        if (state_q.cnt[state_q.ch] == CW'(1))
                            te_set[state_q.ch] = 1'b1;
                        state_d.st = SQ_IDLE;
                    end else if (!cfg_enable) begin
                        state_d.st = SQ_IDLE;
                    end
                end
            end
            default: state_d.st = SQ_IDLE;
        endcase
        state_d.te = (state_q.te & ~te_clear) | te_set;
        if (ld_valid && !(state_q.st == SQ_XFER && state_q.ch == ld_chan)) begin
            state_d.addr[ld_chan] = ld_addr & ~LOW_MASK;
            state_d.cnt[ld_chan]  = ld_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    dma_hint_gate u_hint (
        .active    (state_q.st == SQ_XFER),
        .mode16    (cfg_mode16[state_q.ch]),
        .memdram   (cfg_memdram[state_q.ch]),
        .mode      (rq_mode_e'(cfg_reqmode[2*state_q.ch +: 2])),
        .last_beat (beat_last),
        .hint      (bus_hint)
    );

    assign bus_req   = (state_q.st == SQ_XFER);
    assign bus_addr  = cur_addr;
    assign bus_burst = bus_req && cfg_mode16[state_q.ch];
    assign te_flag   = state_q.te;

endmodule

module dma_burst_seq_chk #(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int BYTES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_enable,
    input logic [NCH-1:0]         cfg_mode16,
    input logic [NCH-1:0]         cfg_memdram,
    input logic [2*NCH-1:0]       cfg_reqmode,
    input logic [NCH-1:0]         te_clear,
    input logic                   bus_req,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_burst,
    input logic                   bus_hint,
    input logic                   bus_done,
    input logic [NCH-1:0]         te_flag,
    input logic [$clog2(NCH)-1:0] act_ch
);

    localparam logic [AW-1:0] STEP = AW'(BYTES);

    AST_HINT_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hint |-> (bus_req && bus_burst)); // R3

    AST_NO_HINT_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_burst && bus_addr[3:2] == 2'b11) |-> !bus_hint); // R3

    AST_HINT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hint |-> (cfg_mode16[act_ch] && !cfg_memdram[act_ch]
                      && !cfg_reqmode[2*act_ch + 1])); // R4 R5

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done && bus_hint && cfg_enable)
        |=> (bus_req && bus_addr == $past(bus_addr) + STEP)); // R2

    AST_CYCLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr))); // R10

    AST_STAY_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !bus_req) |=> !bus_req); // R10

    AST_TE0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (te_flag[0] && !te_clear[0]) |=> te_flag[0]); // R9

    AST_TE1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (te_flag[NCH-1] && !te_clear[NCH-1]) |=> te_flag[NCH-1]); // R9

endmodule

bind dma_burst_seq dma_burst_seq_chk #(.NCH(NCH), .AW(AW), .BYTES(BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_mode16  (cfg_mode16),
    .cfg_memdram (cfg_memdram),
    .cfg_reqmode (cfg_reqmode),
    .te_clear    (te_clear),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_burst   (bus_burst),
    .bus_hint    (bus_hint),
    .bus_done    (bus_done),
    .te_flag     (te_flag),
    .act_ch      (act_ch)
);

// File: tb/dma_burst_seq_test.sv
`timescale 1ns/1ps
module dma_burst_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable;
    logic [1:0]  cfg_chan_en, cfg_mode16, cfg_memdram;
    logic [3:0]  cfg_reqmode;
    logic        ld_valid;
    logic        ld_chan;
    logic [31:0] ld_addr;
    logic [15:0] ld_count;
    logic [1:0]  te_clear, ext_req, mod_req;
    logic        bus_req, bus_burst, bus_hint;
    logic [31:0] bus_addr;
    logic        bus_done = 1'b0;
    logic [1:0]  te_flag;

    int nchk = 0;
    int nerr = 0;
    logic        resp_en = 1'b1;
    int          nlog = 0;
    logic [31:0] log_addr [64];
    logic        log_hint [64];
    logic        log_burst [64];

    always #10 clk = ~clk;

    dma_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_chan_en(cfg_chan_en),
        .cfg_mode16(cfg_mode16), .cfg_memdram(cfg_memdram), .cfg_reqmode(cfg_reqmode),
        .ld_valid(ld_valid), .ld_chan(ld_chan), .ld_addr(ld_addr), .ld_count(ld_count),
        .te_clear(te_clear), .ext_req(ext_req), .mod_req(mod_req),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_burst(bus_burst),
        .bus_hint(bus_hint), .bus_done(bus_done), .te_flag(te_flag)
    );

    // Bus responder and beat logger, working on the falling edge
    always @(negedge clk) begin
        bus_done = bus_req && resp_en && rst_n;
        if (bus_done && nlog < 64) begin
            log_addr[nlog]  = bus_addr;
            log_hint[nlog]  = bus_hint;
            log_burst[nlog] = bus_burst;
            nlog++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_enable = 0; cfg_chan_en = 0; cfg_mode16 = 0;
        cfg_memdram = 0; cfg_reqmode = 0; ld_valid = 0; ld_chan = 0;
        ld_addr = 0; ld_count = 0; te_clear = 0; ext_req = 0; mod_req = 0;
        resp_en = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);
        nlog = 0;
    endtask

    task automatic load(input logic ch, input logic [31:0] a, input logic [15:0] c);
        ld_valid = 1'b1; ld_chan = ch; ld_addr = a; ld_count = c;
        step(1);
        ld_valid = 1'b0;
    endtask

    task automatic wait_te(input int ch, input int max);
        for (int i = 0; i < max && !te_flag[ch]; i++) step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "bus_hint", bus_hint, 0);
        chk("R1", "te_flag", te_flag, 0);
    endtask

    task automatic t_burst_auto();
        do_reset();
        cfg_mode16 = 2'b01;
        load(0, 32'h1000, 2);
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        wait_te(0, 100);
        chk("R6", "beats for two units", nlog, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R2", "burst addr", log_addr[i], 32'h1000 + 4 * i);
            chk("R2", "burst flag", log_burst[i], 1);
            chk("R3", "hint pattern", log_hint[i], (i % 4) != 3);
        end
        chk("R6", "te after count zero", te_flag[0], 1);
        load(0, 32'h2000, 1);
        step(10);
        chk("R9", "no unit while te set", nlog, 8);
        chk("R9", "te sticky", te_flag[0], 1);
        te_clear = 2'b01;
        step(1);
        te_clear = 2'b00;
        wait_te(0, 100);
        chk("R9", "runs after clear", nlog, 12);
        chk("R9", "addr after clear", log_addr[8], 32'h2000);
    endtask

    task automatic t_single();
        do_reset();
        cfg_mode16 = 2'b00;
        load(1, 32'h2000, 3);
        cfg_chan_en = 2'b10; cfg_enable = 1'b1;
        wait_te(1, 100);
        chk("R6", "single unit count", nlog, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2", "single addr", log_addr[i], 32'h2000 + 4 * i);
            chk("R2", "single burst flag", log_burst[i], 0);
            chk("R4", "single no hint", log_hint[i], 0);
        end
        chk("R6", "te ch1", te_flag, 2'b10);
    endtask

    task automatic t_dram();
        do_reset();
        cfg_mode16 = 2'b01; cfg_memdram = 2'b01;
        load(0, 32'h5000, 1);
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        wait_te(0, 100);
        chk("R4", "dram beats", nlog, 4);
        for (int i = 0; i < 4; i++)
            chk("R4", "dram no hint", log_hint[i], 0);
    endtask

    task automatic t_reqmode(input logic [1:0] m, input logic exp_hint);
        do_reset();
        cfg_mode16 = 2'b01; cfg_reqmode = {2'b00, m};
        load(0, 32'h6000, 1);
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        if (m == 2'd2) ext_req = 2'b01;
        if (m == 2'd3) mod_req = 2'b01;
        if (m == 2'd1) begin
            ext_req = 2'b01; step(1); ext_req = 2'b00;
        end
        wait_te(0, 100);
        chk("R5", "mode beats", nlog, 4);
        for (int i = 0; i < 4; i++)
            chk("R5", $sformatf("hint mode %0d", m), log_hint[i], exp_hint && (i != 3));
    endtask

    task automatic t_edge();
        do_reset();
        cfg_mode16 = 2'b01; cfg_reqmode = 4'b0001;
        load(0, 32'h7000, 5);
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        step(5);
        chk("R8", "no edge no unit", nlog, 0);
        ext_req = 2'b01; step(1); ext_req = 2'b00;
        step(30);
        chk("R8", "one edge one unit", nlog, 4);
        ext_req = 2'b01; step(1); ext_req = 2'b00;
        step(30);
        chk("R8", "second edge", nlog, 8);
        chk("R8", "second unit addr", log_addr[4], 32'h7010);
        chk("R8", "te not set", te_flag[0], 0);
    endtask

    task automatic t_priority();
        do_reset();
        load(0, 32'h100, 2);
        load(1, 32'h200, 2);
        cfg_chan_en = 2'b11;
        step(1);
        cfg_enable = 1'b1;
        wait_te(1, 100);
        chk("R7", "beats", nlog, 4);
        chk("R7", "first", log_addr[0], 32'h100);
        chk("R7", "second", log_addr[1], 32'h104);
        chk("R7", "third", log_addr[2], 32'h200);
        chk("R7", "fourth", log_addr[3], 32'h204);
    endtask

    task automatic t_abort();
        do_reset();
        cfg_mode16 = 2'b01;
        load(0, 32'h3000, 3);
        resp_en = 1'b0;
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        step(3);
        chk("R10", "beat pending", bus_req, 1);
        resp_en = 1'b1;
        step(1);
        resp_en = 1'b0; cfg_enable = 1'b0;
        step(4);
        chk("R10", "cycle held", bus_req, 1);
        chk("R10", "addr held", bus_addr, 32'h3004);
        resp_en = 1'b1;
        step(5);
        chk("R10", "idle after abort", bus_req, 0);
        chk("R10", "beats before abort", nlog, 2);
        cfg_enable = 1'b1;
        wait_te(0, 200);
        chk("R10", "resumed total", nlog, 12);
        chk("R10", "resume addr", log_addr[2], 32'h3008);
        chk("R10", "resume addr2", log_addr[3], 32'h300C);
        chk("R10", "final addr", log_addr[11], 32'h302C);
        chk("R10", "te after resume", te_flag[0], 1);
    endtask

    task automatic t_abort_last();
        do_reset();
        load(0, 32'h4000, 1);
        resp_en = 1'b0;
        cfg_chan_en = 2'b01; cfg_enable = 1'b1;
        step(3);
        cfg_enable = 1'b0;
        step(3);
        chk("R11", "last beat held", bus_req, 1);
        resp_en = 1'b1;
        step(3);
        chk("R11", "te on aborted last", te_flag[0], 1);
        chk("R11", "beat count", nlog, 1);
        chk("R11", "idle", bus_req, 0);
    endtask

    initial begin
        t_reset();
        t_burst_auto();
        t_single();
        t_dram();
        t_reqmode(2'd0, 1'b1);
        t_reqmode(2'd1, 1'b1);
        t_reqmode(2'd2, 1'b0);
        t_reqmode(2'd3, 1'b0);
        t_edge();
        t_priority();
        t_abort();
        t_abort_last();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule